// File: doc/BRIEF.md
# Bias Supply Serial Setpoint Controller

This block is the digital control port of a boost converter that biases a photodiode at high voltage. A host writes an 8-bit setpoint over a three-wire serial link: chip-select, serial clock and data. The block synchronizes the three wires into the system clock and assembles the byte. It commits the byte to the DAC code register only when chip-select is released after exactly eight bits. The port is write-only and stays active in every converter state.

The all-zero code is a shutdown command. While the register holds zero, or while the undervoltage input is high, the converter enable is low and the loop-compensation discharge request is high. The block also drives an active-low current-limit indicator. It takes the raw limit comparator, synchronizes it and lets the indicator change only on a tick from the switching oscillator. This keeps switching noise off the pin.

Top module: `bias_spi_ctrl`

## Requirements
- R1: Out of reset the DAC code is 8'hFF (lowest converter output), the current-limit indicator is 1 (not limiting), and the converter enable rises one cycle after reset is released.
- R2: A frame is exactly 8 bits. Data is sampled on rising serial-clock edges while chip-select is low, and the first bit is bit 7 of the code. The DAC code holds its old value until chip-select returns high, then takes the new code.
- R3: A frame ended by chip-select rising after any bit count other than 8 (0, 7 or 9 bits, among others) is dropped, and the DAC code keeps its previous value.
- R4: While the DAC code is 8'h00 the converter enable is 0 and the compensation discharge request is 1. A nonzero code raises the enable on the cycle after the code register changes, provided undervoltage is low.
- R5: While the undervoltage input is high the enable is 0 and the discharge request is 1 for any code, and the stored code is not altered.
- R6: Frames are accepted and committed while the converter is shut down by code 8'h00 or by undervoltage.
- R7: The current-limit indicator is the inverse of the synchronized raw comparator (1 on the raw input means limiting, which gives indicator 0). It is updated only in a cycle where the oscillator tick is high and holds its level otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip-select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data, MSB first |
| ilim_raw_i | input | 1 | Raw current-limit comparator, 1 = over limit |
| osc_tick_i | input | 1 | One-cycle pulse per switching oscillator edge |
| uvlo_i | input | 1 | Supply undervoltage, 1 = undervoltage |
| dac_code_o | output | 8 | Committed DAC setpoint code |
| conv_en_o | output | 1 | Enable to the PWM and gate stage |
| comp_dis_o | output | 1 | Request to discharge loop compensation |
| ilim_n_o | output | 1 | Current-limit indicator, 0 = limiting |

## Verification
The bench sweeps all 256 codes. A bit-order or shift-edge error shows up as a wrong code on many of them. Each committed frame is also checked before chip-select rises, which catches a design that updates the register early. Short, long and empty frames check that a counter which wraps or does not clear leaves a stale or partial code. Code zero and undervoltage are applied while frames keep arriving; a design that gated the port during shutdown, or released the enable on a zero code, would show a wrong enable or a frozen code. The limit indicator is held off-tick after the raw input changes, which exposes a transparent or wrongly polarized indicator.

// File: rtl/bias_ctrl_pkg.sv
package bias_ctrl_pkg;
  typedef enum int unsigned {
    SI_CS   = 0,
    SI_SCLK = 1,
    SI_SDI  = 2,
    SI_ILIM = 3
  } sync_idx_e;
  localparam int unsigned SYNC_LANES = 4;
  // idle levels: cs high, others low
  localparam logic [SYNC_LANES-1:0] SYNC_IDLE = 4'b0001;
endpackage

// File: rtl/bias_sync.sv
module bias_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bias_frame_rx.sv
module bias_frame_rx #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  output logic              load_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CNT_W = $clog2(CODE_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CODE_W + 1);

  logic              cs_q, sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] shreg_q;
  logic              cs_rise, cs_fall, sclk_rise;

  assign cs_rise   = cs_n_s_i & ~cs_q;
  assign cs_fall   = ~cs_n_s_i & cs_q;
  assign sclk_rise = sclk_s_i & ~sclk_q & ~cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      cs_q   <= cs_n_s_i;
      sclk_q <= sclk_s_i;
      if (cs_fall || cs_rise) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[CODE_W-2:0], sdi_s_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign load_o = cs_rise && (cnt_q == CNT_FULL);
  assign code_o = shreg_q;
endmodule

// File: rtl/bias_setpoint.sv
module bias_setpoint #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              uvlo_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              conv_en_o,
  output logic              comp_dis_o
);
  logic [CODE_W-1:0] code_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '1;
      en_q   <= 1'b0;
    end else begin
      if (load_i) code_q <= code_i;
      en_q <= (code_q != '0) && !uvlo_i;
    end
  end

  assign dac_code_o = code_q;
  assign conv_en_o  = en_q;
  assign comp_dis_o = ~en_q;
endmodule

// File: rtl/bias_ilim_flag.sv
module bias_ilim_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ilim_s_i,
  input  logic tick_i,
  output logic ilim_n_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b1;
    else if (tick_i) flag_q <= ~ilim_s_i;
  end

  assign ilim_n_o = flag_q;
endmodule

// File: rtl/bias_spi_ctrl.sv
module bias_spi_ctrl
  import bias_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              ilim_raw_i,
  input  logic              osc_tick_i,
  input  logic              uvlo_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              conv_en_o,
  output logic              comp_dis_o,
  output logic              ilim_n_o
);
  logic [SYNC_LANES-1:0] raw_in, syn;
  logic                  load;
  logic [CODE_W-1:0]     rx_code;

  always_comb begin
    raw_in          = '0;
    raw_in[SI_CS]   = cs_ni;
    raw_in[SI_SCLK] = sclk_i;
    raw_in[SI_SDI]  = sdi_i;
    raw_in[SI_ILIM] = ilim_raw_i;
  end

  bias_sync #(.W(SYNC_LANES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(syn)
  );

  bias_frame_rx #(.CODE_W(CODE_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_n_s_i(syn[SI_CS]), .sclk_s_i(syn[SI_SCLK]), .sdi_s_i(syn[SI_SDI]),
    .load_o(load), .code_o(rx_code)
  );

  bias_setpoint #(.CODE_W(CODE_W)) u_sp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .code_i(rx_code),
    .uvlo_i(uvlo_i), .dac_code_o(dac_code_o),
    .conv_en_o(conv_en_o), .comp_dis_o(comp_dis_o)
  );

  bias_ilim_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .ilim_s_i(syn[SI_ILIM]),
    .tick_i(osc_tick_i), .ilim_n_o(ilim_n_o)
  );
endmodule

// File: rtl/bias_spi_ctrl_chk.sv
module bias_spi_ctrl_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              osc_tick_i,
  input logic              uvlo_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              conv_en_o,
  input logic              comp_dis_o,
  input logic              ilim_n_o
);
  // R2: code moves only once chip-select has been high for two samples
  assert_commit_on_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o != $past(dac_code_o)) |-> ($past(cs_ni) && $past(cs_ni, 2)));

  assert_zero_code_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o == '0) |=> (!conv_en_o && comp_dis_o));

  assert_enable_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_en_o) |-> (($past(dac_code_o) != '0) && !$past(uvlo_i)));

  assert_uvlo_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (!conv_en_o && comp_dis_o));

  assert_flag_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilim_n_o != $past(ilim_n_o)) |-> $past(osc_tick_i));
endmodule

bind bias_spi_ctrl bias_spi_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .osc_tick_i(osc_tick_i),
  .uvlo_i(uvlo_i), .dac_code_o(dac_code_o), .conv_en_o(conv_en_o),
  .comp_dis_o(comp_dis_o), .ilim_n_o(ilim_n_o)
);

// File: tb/sim_bias_spi_ctrl.sv
`timescale 1ns/1ps
module sim_bias_spi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic ilim_raw = 1'b0, tick = 1'b0, uvlo = 1'b0;
  logic [7:0] dac_code;
  logic conv_en, comp_dis, ilim_n;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [7:0] exp_code = 8'hFF;

  always #4 clk = ~clk;

  bias_spi_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .ilim_raw_i(ilim_raw), .osc_tick_i(tick), .uvlo_i(uvlo),
    .dac_code_o(dac_code), .conv_en_o(conv_en), .comp_dis_o(comp_dis),
    .ilim_n_o(ilim_n)
  );

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // send nbits, MSB of the nbits-wide word first
  task automatic send(input logic [15:0] data, input int nbits);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(6);
    check("R2 hold before release", dac_code, exp_code);
    cs_n = 1'b1;
    wait_clk(8);
    if (nbits == 8) exp_code = data[7:0];
    check(nbits == 8 ? "R2 commit" : "R3 drop", dac_code, exp_code);
  endtask

  task automatic check_en(input string req);
    wait_clk(2);
    check(req, conv_en, (exp_code != 0) && !uvlo);
    check(req, comp_dis, !((exp_code != 0) && !uvlo));
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles >= 200000) begin
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    wait_clk(3);
    // R1 reset state
    check("R1 code", dac_code, 8'hFF);
    check("R1 flag", ilim_n, 1);
    check("R1 en in reset", conv_en, 0);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 en after reset", conv_en, 1);

    // R2 all codes, R4 enable follows each
    for (int c = 0; c < 256; c++) begin
      send(16'(c), 8);
      check_en("R4 enable vs code");
    end

    // R3 bad bit counts
    send(16'h00A5, 8);
    send(16'h0033, 7);
    send(16'h01C3, 9);
    send(16'h0000, 0);
    send(16'h00FF, 4);
    check("R3 code kept", dac_code, 8'hA5);

    // R4 shutdown then release; R6 frames accepted in shutdown
    send(16'h0000, 8);
    check_en("R4 shutdown");
    send(16'h005A, 8);
    check("R6 accept in shutdown", dac_code, 8'h5A);
    check_en("R4 release");

    // R5 undervoltage; R6 frames during it
    uvlo = 1'b1;
    check_en("R5 uvlo off");
    check("R5 code kept", dac_code, 8'h5A);
    send(16'h0081, 8);
    check("R6 accept in uvlo", dac_code, 8'h81);
    check_en("R5 uvlo still off");
    uvlo = 1'b0;
    check_en("R5 uvlo released");

    // R7 flag updates only on tick
    ilim_raw = 1'b1;
    wait_clk(12);
    check("R7 no tick hold", ilim_n, 1);
    tick = 1'b1;
    wait_clk(1);
    tick = 1'b0;
    wait_clk(1);
    check("R7 limiting", ilim_n, 0);
    ilim_raw = 1'b0;
    wait_clk(12);
    check("R7 no tick hold low", ilim_n, 0);
    tick = 1'b1;
    wait_clk(1);
    tick = 1'b0;
    wait_clk(1);
    check("R7 released", ilim_n, 1);
    tick = 1'b1;
    wait_clk(3);
    tick = 1'b0;
    wait_clk(1);
    check("R7 repeated tick steady", ilim_n, 1);

    done = 1'b1;
    finish_run();
  end
endmodule